// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Engine

This block moves received frames from a byte stream into system memory through a ring of descriptors. Each descriptor is four 32-bit words (16 bytes). Word 0 holds the address of a fixed-size receive buffer. Word 1 (byte offset 4) carries the status and length that the engine writes back. Software fills the ring, programs its base address and entry count, and then enables the engine. For every frame, the engine fetches the buffer address of the descriptor at its own index and writes the frame bytes into that buffer in order. It then posts completion with one full-word store of the done flag, the last-segment flag and the stored length.

Ownership works through a release index. Software writes the index of the last descriptor it has handed back to hardware. The engine may fill its own slot only while its index differs from that release index. A frame that arrives when no slot is free is consumed and discarded, and a drop counter records it. Writing the ring size minus one to the release index at start-up makes every slot but one available.

A buffer holds 2048 bytes. Longer frames are truncated: the surplus bytes are still taken from the stream but are never written. Writing 1 to the index-clear control returns the engine's own index to zero.

Top module: `rx_ring_dma`

## Requirements
- R1: The register map uses these byte offsets: ring base 0x00; entry count 0x04; release index 0x08; control 0x0C (bit 0 is enable and reads back, bit 1 reads busy); index clear 0x10 (write bit 0); engine index 0x14 (read only); drop count 0x18 (read only). Every register resets to zero, and s_ready_o and mem_req_o are low after reset.
- R2: For a frame taken into slot i, the engine reads word 0 at base+16*i to get the buffer address. It then writes byte n of the frame to buffer+n using a word-aligned address, a one-hot byte enable on lane addr[1:0], and the byte replicated on all four lanes.
- R3: After the last data write is granted, the engine issues exactly one full-word write (enable 4'hF) to base+16*i+4. That word has bit 31 (done) set, bit 30 (last segment) set, bits 29:16 holding the stored length, and bits 15:0 zero.
- R4: After the write-back is granted, the engine index moves to i+1, and wraps to 0 when i+1 reaches the entry count.
- R5: If the engine index equals the release index when a frame starts, the frame is consumed and discarded. No memory access is made, the engine index stays put, and the drop count increases by one.
- R6: Only the first 2048 bytes of a frame are stored, and the reported length is capped at 2048. Bytes past that point are accepted from the stream but never written to memory.
- R7: Writing 1 to the index clear forces the engine index to 0. This takes priority over an index advance in the same cycle.
- R8: Busy is high from the start of a frame until its write-back (or its discard) completes. Clearing enable mid-frame lets that frame finish. While the engine is idle and disabled, s_ready_o stays low, and the engine takes no frame and counts no drop.
- R9: A memory request that is not granted stays asserted, with its address and direction unchanged, until it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| s_data_i | input | 8 | Frame byte |
| s_valid_i | input | 1 | Frame byte valid |
| s_last_i | input | 1 | Marks the last byte of a frame |
| s_ready_o | output | 1 | Engine accepts the byte this cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid, one read outstanding at most |
| mem_rdata_i | input | 32 | Read data |

## Verification
The index-clear control and the index advance at write-back can both fall in the same cycle. The bench provokes this by withholding the grant while the engine presents its write-back. It then asserts the grant and writes the index clear on the same clock edge. The result is judged correct when the engine index reads back as zero and the descriptor still shows the done word, so neither action was lost. The full-ring case is judged at the ports as well: the drop count goes up, the engine index is unchanged, and no memory write occurs.

// File: rtl/rx_ring_dma_pkg.sv
`timescale 1ns/1ps
package rx_ring_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ADDR, ST_DATA, ST_WB, ST_DROP
  } eng_state_e;

  localparam logic [7:0] OFS_BASE  = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h04;
  localparam logic [7:0] OFS_REL   = 8'h08;
  localparam logic [7:0] OFS_CTRL  = 8'h0C;
  localparam logic [7:0] OFS_CLR   = 8'h10;
  localparam logic [7:0] OFS_HWIDX = 8'h14;
  localparam logic [7:0] OFS_DROP  = 8'h18;

  localparam int DESC_LG  = 4;   // 16-byte descriptors
  localparam int STAT_OFS = 4;   // status word byte offset
  localparam int LEN_W    = 14;  // status length field width
endpackage

// File: rtl/rx_ring_dma_regs.sv
`timescale 1ns/1ps
module rx_ring_dma_regs
  import rx_ring_dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IDX_W  = 8,
  parameter int DROP_W = 16,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [IDX_W-1:0] hw_idx_i,
  input  logic             busy_i,
  input  logic             drop_i,
  output logic [AW-1:0]    base_o,
  output logic [CNT_W-1:0] count_o,
  output logic [IDX_W-1:0] rel_idx_o,
  output logic             en_o,
  output logic             clr_o
);
  logic [DROP_W-1:0] drop_q;
  logic              wdata_unused;

  assign wdata_unused = ^wdata_i;
  assign clr_o = we_i && (addr_i == OFS_CLR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o    <= '0;
      count_o   <= '0;
      rel_idx_o <= '0;
      en_o      <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        OFS_BASE:  base_o    <= wdata_i[AW-1:0];
        OFS_COUNT: count_o   <= wdata_i[CNT_W-1:0];
        OFS_REL:   rel_idx_o <= wdata_i[IDX_W-1:0];
        OFS_CTRL:  en_o      <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // saturating drop counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                drop_q <= '0;
    else if (drop_i && !(&drop_q)) drop_q <= drop_q + 1'b1;
  end

  always_comb begin
    case (addr_i)
      OFS_BASE:  rdata_o = 32'(base_o);
      OFS_COUNT: rdata_o = 32'(count_o);
      OFS_REL:   rdata_o = 32'(rel_idx_o);
      OFS_CTRL:  rdata_o = {30'd0, busy_i, en_o};
      OFS_HWIDX: rdata_o = 32'(hw_idx_i);
      OFS_DROP:  rdata_o = 32'(drop_q);
      default:   rdata_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/rx_ring_dma_engine.sv
`timescale 1ns/1ps
module rx_ring_dma_engine
  import rx_ring_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048,
  localparam int CNT_W    = IDX_W + 1,
  localparam int LCNT_W   = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [IDX_W-1:0] rel_idx_i,
  input  logic             clr_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [3:0]       mem_be_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic [IDX_W-1:0] hw_idx_o,
  output logic             busy_o,
  output logic             drop_o
);
  eng_state_e        state_q;
  logic [IDX_W-1:0]  idx_q, idx_next;
  logic [AW-1:0]     buf_q, waddr_q, desc_addr;
  logic [LCNT_W-1:0] len_q;
  logic [7:0]        wbyte_q;
  logic              pend_q, last_q, full, take;

  assign desc_addr = base_i + AW'({idx_q, {DESC_LG{1'b0}}});
  assign full      = (idx_q == rel_idx_i);
  assign idx_next  = ((CNT_W'(idx_q) + 1'b1) >= count_i) ? '0 : idx_q + 1'b1;
  assign take      = s_ready_o && s_valid_i;
  assign drop_o    = (state_q == ST_IDLE) && en_i && s_valid_i && full;
  assign busy_o    = (state_q != ST_IDLE);
  assign hw_idx_o  = idx_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_be_o    = 4'h0;
    mem_wdata_o = 32'd0;
    s_ready_o   = 1'b0;
    case (state_q)
      ST_FETCH: mem_req_o = 1'b1;
      ST_DATA: begin
        mem_req_o   = pend_q;
        mem_we_o    = 1'b1;
        mem_addr_o  = {waddr_q[AW-1:2], 2'b00};
        mem_be_o    = 4'b0001 << waddr_q[1:0];
        mem_wdata_o = {4{wbyte_q}};
        s_ready_o   = !pend_q && !last_q;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + AW'(STAT_OFS);
        mem_be_o    = 4'hF;
        mem_wdata_o = {1'b1, 1'b1, LEN_W'(len_q), 16'h0000};
      end
      ST_DROP: s_ready_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      buf_q   <= '0;
      waddr_q <= '0;
      len_q   <= '0;
      wbyte_q <= '0;
      pend_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:  if (en_i && s_valid_i) state_q <= full ? ST_DROP : ST_FETCH;
        ST_FETCH: if (mem_gnt_i) state_q <= ST_ADDR;
        ST_ADDR: if (mem_rvalid_i) begin
          buf_q   <= mem_rdata_i[AW-1:0];
          len_q   <= '0;
          pend_q  <= 1'b0;
          last_q  <= 1'b0;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (pend_q && mem_gnt_i) pend_q <= 1'b0;
          if (take) begin
            if (len_q < LCNT_W'(BUF_BYTES)) begin   // bytes past the page are dropped
              pend_q  <= 1'b1;
              waddr_q <= buf_q + AW'(len_q);
              wbyte_q <= s_data_i;
              len_q   <= len_q + 1'b1;
            end
            if (s_last_i) last_q <= 1'b1;
          end
          if (last_q && !pend_q) state_q <= ST_WB;
        end
        ST_WB:   if (mem_gnt_i) state_q <= ST_IDLE;
        ST_DROP: if (s_valid_i && s_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // clear wins over the write-back advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               idx_q <= '0;
    else if (clr_i)                            idx_q <= '0;
    else if (state_q == ST_WB && mem_gnt_i)    idx_q <= idx_next;
  end
endmodule

// File: rtl/rx_ring_dma.sv
`timescale 1ns/1ps
module rx_ring_dma #(
  parameter int AW        = 32,
  parameter int IDX_W     = 8,
  parameter int DROP_W    = 16,
  parameter int BUF_BYTES = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [7:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [7:0]    s_data_i,
  input  logic          s_valid_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i
);
  localparam int CNT_W = IDX_W + 1;

  logic [AW-1:0]    ring_base;
  logic [CNT_W-1:0] ring_count;
  logic [IDX_W-1:0] rel_idx, hw_idx;
  logic             eng_en, idx_clr, eng_busy, drop_evt;

  rx_ring_dma_regs #(.AW(AW), .IDX_W(IDX_W), .DROP_W(DROP_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .hw_idx_i(hw_idx), .busy_i(eng_busy), .drop_i(drop_evt),
    .base_o(ring_base), .count_o(ring_count), .rel_idx_o(rel_idx),
    .en_o(eng_en), .clr_o(idx_clr)
  );

  rx_ring_dma_engine #(.AW(AW), .IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) i_engine (
    .clk_i, .rst_ni,
    .en_i(eng_en), .base_i(ring_base), .count_i(ring_count),
    .rel_idx_i(rel_idx), .clr_i(idx_clr),
    .s_data_i, .s_valid_i, .s_last_i, .s_ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .hw_idx_o(hw_idx), .busy_o(eng_busy), .drop_o(drop_evt)
  );
endmodule

// File: rtl/rx_ring_dma_chk.sv
`timescale 1ns/1ps
module rx_ring_dma_chk #(
  parameter int AW        = 32,
  parameter int IDX_W     = 8,
  parameter int BUF_BYTES = 2048
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_i,
  input logic             mem_we_i,
  input logic [AW-1:0]    mem_addr_i,
  input logic [3:0]       mem_be_i,
  input logic [31:0]      mem_wdata_i,
  input logic             mem_gnt_i,
  input logic [IDX_W-1:0] hw_idx_i,
  input logic [IDX_W-1:0] rel_idx_i,
  input logic             clr_i
);
  logic rd_req;
  assign rd_req = mem_req_i && !mem_we_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_gnt_i |=> mem_req_i && $stable(mem_addr_i) && $stable(mem_we_i)); // R9

  AST_DATA_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_we_i && mem_be_i != 4'hF |-> $onehot(mem_be_i)); // R2

  AST_WB_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_we_i && mem_be_i == 4'hF |->
      mem_wdata_i[31] && mem_wdata_i[30] && mem_wdata_i[15:0] == 16'h0 &&
      mem_wdata_i[29:16] != 14'd0 && mem_wdata_i[29:16] <= 14'(BUF_BYTES)); // R3

  AST_NO_FILL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && !$past(rd_req) |-> hw_idx_i != rel_idx_i); // R5

  AST_IDX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> hw_idx_i == '0); // R7
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.AW(AW), .IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) i_rx_ring_dma_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_i(mem_req_o), .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o),
  .mem_be_i(mem_be_o), .mem_wdata_i(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
  .hw_idx_i(hw_idx), .rel_idx_i(rel_idx), .clr_i(idx_clr)
);

// File: tb/test_rx_ring_dma.sv
`timescale 1ns/1ps
module test_rx_ring_dma;
  localparam int AW = 32;
  localparam int MEM_WORDS = 2048;
  localparam int PAGE = 2048;
  localparam int NV = 6;
  localparam int VLEN   [NV] = '{1, 4, 61, 2048, 2050, 7};
  localparam int VSEED  [NV] = '{8'h11, 8'h20, 8'h5A, 8'h00, 8'h80, 8'hC3};
  localparam int VSTALL [NV] = '{0, 1, 0, 1, 0, 1};
  localparam logic [7:0] A_BASE = 8'h00, A_CNT = 8'h04, A_REL = 8'h08, A_CTRL = 8'h0C,
                         A_CLR = 8'h10, A_HW = 8'h14, A_DROP = 8'h18;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          reg_we_i = 1'b0;
  logic [7:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0, reg_rdata_o;
  logic [7:0]    s_data_i = '0;
  logic          s_valid_i = 1'b0, s_last_i = 1'b0, s_ready_o;
  logic          mem_req_o, mem_we_o, mem_gnt_i;
  logic [AW-1:0] mem_addr_o;
  logic [3:0]    mem_be_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i = '0;
  logic          mem_rvalid_i = 1'b0;

  rx_ring_dma i_rx_ring_dma (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .s_data_i, .s_valid_i, .s_last_i, .s_ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i
  );

  logic [31:0] mem [MEM_WORDS];
  int  cyc = 0, wr_cnt = 0, checks = 0, fails = 0;
  bit  gnt_en = 1'b1, stall_on = 1'b0, hold_wb = 1'b0;
  wire is_wb = mem_req_o && mem_we_o && mem_be_o == 4'hF;
  assign mem_gnt_i = gnt_en && !(stall_on && cyc[1:0] == 2'b11) && !(hold_wb && is_wb);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    mem_rvalid_i <= 1'b0;
    if (mem_req_o && mem_gnt_i) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[12:2]][8*b +: 8] = mem_wdata_o[8*b +: 8];
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata_i  <= mem[mem_addr_o[12:2]];
        mem_rvalid_i <= 1'b1;
      end
    end
  end

  function automatic logic [7:0] mbyte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  function automatic int buf_of(input int i);
    return 32'h100 + i * 32'h800;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic send_bytes(input int seed, input int from, input int n, input bit end_frame);
    for (int k = from; k < from + n; k++) begin
      bit acc = 1'b0;
      while (!acc) begin
        @(negedge clk_i);
        s_valid_i = 1'b1;
        s_data_i  = 8'(seed + k);
        s_last_i  = end_frame && (k == from + n - 1);
        #2 acc = s_ready_o;
        @(posedge clk_i);
      end
    end
    @(negedge clk_i);
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  task automatic wait_idx(input logic [31:0] old, input string req);
    logic [31:0] v;
    for (int t = 0; t < 30000; t++) begin
      reg_rd(A_HW, v);
      if (v != old) return;
    end
    chk(1'b0, req, v, old + 1);
  endtask

  task automatic release_slot(input int i);
    mem[i*4 + 3] = 32'h0;
    mem[i*4 + 1] = 32'h4000_0000;
    reg_wr(A_REL, i);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual %h expected %h", 32'(cyc), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_w;
    logic [7:0]  beyond;
    int idx, stored, bad, w0;

    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hEEEE_EEEE;
    for (int i = 0; i < 3; i++) begin
      mem[i*4]     = buf_of(i);
      mem[i*4 + 1] = 32'h4000_0000;
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // reset state
    chk(!s_ready_o && !mem_req_o, "R1 ready/req after reset", {s_ready_o, mem_req_o}, 0);
    reg_rd(A_CTRL, v);  chk(v == 0, "R1 control reset", v, 0);
    reg_rd(A_HW, v);    chk(v == 0, "R1 index reset", v, 0);
    reg_rd(A_DROP, v);  chk(v == 0, "R1 drop reset", v, 0);
    reg_rd(A_CNT, v);   chk(v == 0, "R1 count reset", v, 0);

    reg_wr(A_BASE, 32'h0);
    reg_wr(A_CNT, 3);
    reg_wr(A_REL, 2);
    reg_wr(A_CTRL, 1);
    reg_rd(A_CNT, v);  chk(v == 3, "R1 count readback", v, 3);
    reg_rd(A_CTRL, v); chk(v == 1, "R1 enable readback", v, 1);

    // table walk
    for (int t = 0; t < NV; t++) begin
      idx = t % 3;
      stall_on = VSTALL[t][0];
      stored = (VLEN[t] > PAGE) ? PAGE : VLEN[t];
      beyond = mbyte(buf_of(idx) + PAGE);
      send_bytes(VSEED[t], 0, VLEN[t], 1'b1);
      wait_idx(idx, "R4 advance");
      exp_w = {2'b11, 14'(stored), 16'h0};
      chk(mem[idx*4 + 1] == exp_w, "R3 status word", mem[idx*4 + 1], exp_w);
      bad = 0;
      for (int k = 0; k < stored; k++)
        if (mbyte(buf_of(idx) + k) != 8'(VSEED[t] + k)) bad++;
      chk(bad == 0, VSTALL[t] != 0 ? "R9 data under stalls" : "R2 data bytes", bad, 0);
      chk(mbyte(buf_of(idx) + PAGE) == beyond, "R6 no write past page",
          mbyte(buf_of(idx) + PAGE), beyond);
      reg_rd(A_HW, v);
      chk(v == (t + 1) % 3, "R4 index wrap", v, (t + 1) % 3);
      release_slot(idx);
    end
    stall_on = 1'b0;

    // ring full: fill slots 0 and 1 without release (release index is 2)
    send_bytes(8'h31, 0, 3, 1'b1); wait_idx(0, "R4 advance");
    send_bytes(8'h41, 0, 3, 1'b1); wait_idx(1, "R4 advance");
    w0 = wr_cnt;
    send_bytes(8'h51, 0, 10, 1'b1);
    repeat (5) @(posedge clk_i);
    reg_rd(A_DROP, v); chk(v == 1, "R5 drop count", v, 1);
    reg_rd(A_HW, v);   chk(v == 2, "R5 index held", v, 2);
    chk(wr_cnt == w0, "R5 no memory write", wr_cnt, w0);
    chk(mem[2*4 + 1] == 32'h4000_0000, "R5 descriptor untouched", mem[9], 32'h4000_0000);
    release_slot(0);
    release_slot(1);

    // clear collides with write-back advance
    hold_wb = 1'b1;
    send_bytes(8'h61, 0, 5, 1'b1);
    begin
      bit seen = 1'b0;
      for (int t = 0; t < 200 && !seen; t++) begin
        @(negedge clk_i);
        seen = is_wb;
      end
      chk(seen, "R7 write-back pending", seen, 1);
    end
    reg_we_i = 1'b1; reg_addr_i = A_CLR; reg_wdata_i = 32'h1; hold_wb = 1'b0;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    reg_rd(A_HW, v); chk(v == 0, "R7 clear wins", v, 0);
    exp_w = {2'b11, 14'd5, 16'h0};
    chk(mem[2*4 + 1] == exp_w, "R7 status still written", mem[9], exp_w);

    // disable mid-frame
    mem[1] = 32'h4000_0000;
    send_bytes(8'h71, 0, 6, 1'b0);
    reg_wr(A_CTRL, 0);
    reg_rd(A_CTRL, v); chk(v == 2, "R8 busy mid-frame", v, 2);
    send_bytes(8'h71, 6, 6, 1'b1);
    wait_idx(0, "R8 frame finishes");
    exp_w = {2'b11, 14'd12, 16'h0};
    chk(mem[1] == exp_w, "R8 status after disable", mem[1], exp_w);
    reg_rd(A_CTRL, v); chk(v == 0, "R8 idle flag", v, 0);
    begin
      int rdy = 0;
      w0 = wr_cnt;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk_i);
        s_valid_i = 1'b1; s_last_i = 1'b1; s_data_i = 8'(t);
        #2 if (s_ready_o || mem_req_o) rdy++;
      end
      @(negedge clk_i) s_valid_i = 1'b0; s_last_i = 1'b0;
      chk(rdy == 0, "R8 disabled takes nothing", rdy, 0);
    end
    reg_rd(A_DROP, v); chk(v == 1, "R8 no drop while disabled", v, 1);
    reg_rd(A_HW, v);   chk(v == 1, "R8 index unchanged", v, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule